// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block adds or subtracts two integers held as a sign bit plus an N-bit magnitude. On an accepted start it captures both operands and the requested operation. It then runs one pass through a single ripple adder. The result, with its own sign, is left in an accumulator-style register pair that stays visible on the outputs until the next accepted start.

The block first compares the operand signs and the opcode to decide whether the magnitudes must be summed or differenced. It adds through the adder with a mode bit that either passes B straight through with no carry-in, or inverts B with a carry-in of one. The carry out of the adder is kept in an end-carry flop.

A summation that carries out raises the overflow flag. A difference that leaves no end carry means B was the larger magnitude. In that case a second pass through the same adder replaces the accumulator by its two's complement and flips the sign. A difference of exactly zero is always reported with a positive sign.

Top module: `sm_addsub`

## Requirements
- R1: While and right after reset, busy, done and ovf are 0, res_mag is 0 and res_sgn is 0 (positive).
- R2: start is accepted only while busy is 0; the operands and op_sub are sampled at that edge, and later changes to them, or a start pulse while busy is 1, do not change the running operation or its result.
- R3: When the effective operation is a summation (op_sub=0 with equal signs, or op_sub=1 with differing signs; sign bit 1 means negative), res_mag is the sum of the magnitudes modulo 2^N and res_sgn equals the sign of A.
- R4: ovf is cleared at each accepted start and is set only when a summation carries out of the N-bit magnitude; a difference never sets it.
- R5: On a difference with |A| > |B|, res_mag is |A|-|B| and res_sgn equals the sign of A.
- R6: On a difference with |A| < |B|, res_mag is |B|-|A| and res_sgn is the inverse of the sign of A.
- R7: A difference with |A| = |B| gives res_mag 0 with res_sgn 0, whatever the operand signs.
- R8: With start accepted at edge k, busy is 1 from edge k until done; done is a one-cycle pulse after edge k+1 for a summation and after edge k+2 for a difference, and busy is 0 in the done cycle.
- R9: res_mag, res_sgn and ovf hold their values while the block is idle and no start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_sub | input | 1 | 0 = add, 1 = subtract (A minus B) |
| a_mag | input | N | Magnitude of operand A |
| a_sgn | input | 1 | Sign of operand A, 1 = negative |
| b_mag | input | N | Magnitude of operand B |
| b_sgn | input | 1 | Sign of operand B, 1 = negative |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| res_mag | output | N | Result magnitude (accumulator) |
| res_sgn | output | 1 | Result sign (accumulator) |
| ovf | output | 1 | Magnitude summation overflowed |

## Verification
The done pulse of one operation and the acceptance of the next start can fall in the same cycle, because busy is already low while done is high. The bench provokes this by holding start high across the end of an operation, so that a fresh operand set is taken on the done edge. It then judges that the finished result was visible in the done cycle, that ovf was cleared by the new start, and that the follow-on result and its latency match the reference model. A start pulse driven while the unit is busy is also checked to leave the running result untouched.

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_sub,
  input  logic [N-1:0] a_mag,
  input  logic         a_sgn,
  input  logic [N-1:0] b_mag,
  input  logic         b_sgn,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] res_mag,
  output logic         res_sgn,
  output logic         ovf
);

  typedef enum logic [1:0] {S_IDLE, S_ARITH, S_FIX} state_t;

  state_t       st;
  logic [N-1:0] acc_q, bop_q;
  logic         acc_s_q, bop_s_q, sub_q;
  logic         ecar_q, ovf_q, done_q;

  // effective operation: sum the magnitudes when signs agree for add, differ for subtract
  logic mag_sum, mode_m, fix_cmpl;
  assign mag_sum  = ~(acc_s_q ^ bop_s_q ^ sub_q);
  assign mode_m   = ~mag_sum;
  assign fix_cmpl = (st == S_FIX);

  // one shared adder: A + B, A + ~B + 1, or ~A + 0 + 1 for the correction pass
  logic [N-1:0] add_x, add_y;
  logic         add_cin;
  logic [N:0]   add_sum;
  assign add_x   = fix_cmpl ? ~acc_q : acc_q;
  assign add_y   = fix_cmpl ? '0 : (mode_m ? ~bop_q : bop_q);
  assign add_cin = fix_cmpl | mode_m;
  assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{N{1'b0}}, add_cin};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      acc_q   <= '0;
      bop_q   <= '0;
      acc_s_q <= 1'b0;
      bop_s_q <= 1'b0;
      sub_q   <= 1'b0;
      ecar_q  <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          acc_q   <= a_mag;
          acc_s_q <= a_sgn;
          bop_q   <= b_mag;
          bop_s_q <= b_sgn;
          sub_q   <= op_sub;
          ovf_q   <= 1'b0;
          st      <= S_ARITH;
        end
        S_ARITH: begin
          acc_q  <= add_sum[N-1:0];
          ecar_q <= add_sum[N];
          if (mag_sum) begin
            ovf_q  <= add_sum[N];
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_FIX;
          end
        end
        S_FIX: begin
          if (!ecar_q) begin
            acc_q   <= add_sum[N-1:0];
            acc_s_q <= ~acc_s_q;
          end else if (acc_q == '0) begin
            acc_s_q <= 1'b0;
          end
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign res_mag = acc_q;
  assign res_sgn = acc_s_q;
  assign ovf     = ovf_q;

endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] res_mag,
  input logic         res_sgn,
  input logic         ovf
);

  assert_accept_clears_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !ovf));

  assert_ovf_only_at_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(res_mag) && $stable(res_sgn) && $stable(ovf)));

endmodule

bind sm_addsub sm_addsub_chk #(.N(N)) u_chk (.*);

// File: tb/sm_addsub_test.sv
`timescale 1ns/1ps
module sm_addsub_test;
  localparam int N = 8;
  localparam int MODV = 1 << N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_sub = 1'b0, a_sgn = 1'b0, b_sgn = 1'b0;
  logic [N-1:0] a_mag = '0, b_mag = '0;
  logic busy, done, res_sgn, ovf;
  logic [N-1:0] res_mag;

  always #2.5 clk = ~clk;

  sm_addsub #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_mag(a_mag), .a_sgn(a_sgn), .b_mag(b_mag), .b_sgn(b_sgn),
    .busy(busy), .done(done), .res_mag(res_mag), .res_sgn(res_sgn), .ovf(ovf));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit    m_busy, m_done, m_ovf, m_sgn, p_ovf, p_sgn, m_first;
  int    m_mag, p_mag, m_cnt;
  string m_tag = "R1", p_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ovf = 0; m_sgn = 0; m_mag = 0; m_cnt = 0;
      m_first = 0; m_tag = "R1";
    end else if (!m_busy && start) begin
      int a, b;
      bit sa, sb;
      a = int'(a_mag); b = int'(b_mag); sa = a_sgn; sb = b_sgn;
      if ((sa == sb) != op_sub) begin
        p_mag = (a + b) % MODV; p_ovf = (a + b) >= MODV; p_sgn = sa;
        p_tag = p_ovf ? "R4" : "R3"; m_cnt = 1;
      end else if (a >= b) begin
        p_mag = a - b; p_ovf = 0; p_sgn = (p_mag == 0) ? 1'b0 : sa;
        p_tag = (p_mag == 0) ? "R7" : "R5"; m_cnt = 2;
      end else begin
        p_mag = b - a; p_ovf = 0; p_sgn = ~sa; p_tag = "R6"; m_cnt = 2;
      end
      m_busy = 1; m_done = 0; m_ovf = 0; m_first = 1;
    end else if (m_busy) begin
      if (m_first) begin m_ovf = p_ovf; m_first = 0; end
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1; m_mag = p_mag; m_sgn = p_sgn; m_tag = p_tag;
      end else m_done = 0;
    end else begin
      m_done = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 busy", int'(busy), int'(m_busy));
      chk("R8 done", int'(done), int'(m_done));
      chk("R4 ovf", int'(ovf), int'(m_ovf));
      if (!m_busy) begin
        chk(m_done ? {m_tag, " mag"} : "R9 mag", int'(res_mag), m_mag);
        chk(m_done ? {m_tag, " sgn"} : "R9 sgn", int'(res_sgn), int'(m_sgn));
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_done();
    while (!m_done) @(negedge clk);
  endtask

  task automatic do_op(input int a, input bit sa, input int b, input bit sb, input bit sub);
    @(negedge clk);
    a_mag = N'(a); a_sgn = sa; b_mag = N'(b); b_sgn = sb; op_sub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_mag = N'($urandom); b_mag = N'($urandom); a_sgn = ~sa; b_sgn = ~sb; op_sub = ~sub;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 mag", int'(res_mag), 0);
    chk("R1 sgn", int'(res_sgn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", int'(busy), 0);

    do_op(5, 0, 3, 0, 0);      // R3 +5 + +3
    do_op(200, 0, 100, 0, 0);  // R4 overflow
    do_op(5, 0, 3, 1, 1);      // R3 +5 - -3
    do_op(9, 0, 4, 0, 1);      // R5
    do_op(4, 0, 9, 0, 1);      // R6
    do_op(4, 1, 9, 0, 0);      // R6 -4 + +9
    do_op(7, 1, 7, 0, 0);      // R7
    do_op(0, 1, 0, 1, 1);      // R7 -0 - -0
    do_op(255, 1, 255, 1, 0);  // R4 -255 + -255
    do_op(255, 0, 1, 0, 0);    // R4 wraps to 0
    do_op(30, 0, 12, 0, 1);    // R4 ovf cleared by new start

    // R2: start while busy is ignored
    @(negedge clk);
    a_mag = 8'd50; a_sgn = 0; b_mag = 8'd20; b_sgn = 0; op_sub = 1; start = 1;
    @(negedge clk);
    a_mag = 8'd1; b_mag = 8'd2; op_sub = 0; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    chk("R2 ignored start mag", int'(res_mag), 30);
    chk("R2 ignored start sgn", int'(res_sgn), 0);

    // done and a new start in the same cycle
    @(negedge clk);
    a_mag = 8'd150; a_sgn = 0; b_mag = 8'd150; b_sgn = 0; op_sub = 0; start = 1;
    @(negedge clk);
    a_mag = 8'd10; b_mag = 8'd25; op_sub = 1;
    wait_done();
    chk("R4 overflow in done cycle", int'(ovf), 1);
    @(negedge clk);
    start = 0;
    chk("R4 ovf cleared on back-to-back start", int'(ovf), 0);
    wait_done();
    chk("R6 back-to-back mag", int'(res_mag), 15);
    chk("R6 back-to-back sgn", int'(res_sgn), 1);

    for (int i = 0; i < 300; i++)
      do_op(int'($urandom_range(0, MODV - 1)), 1'($urandom),
            (i % 5 == 0) ? -1 : int'($urandom_range(0, MODV - 1)), 1'($urandom), 1'($urandom));

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule